// File: doc/BRIEF.md
# DRAM In-Memory Logic Command Sequencer

This block turns a request for an in-memory operation into a timed stream of DRAM commands on a small command bus. Three operations are supported. The first is a row copy. The other two are a bitwise AND and a bitwise OR of two rows, written to a third row. The intervals between commands are programmable per request and are meant to be shorter than normal DRAM timing. A shortened gap makes the array either move a row onto another row or open three rows at once, and the shared bit-lines then settle to the logic result.

A logic operation never works on its operands in place. The block first copies operand A into the subarray row with low bits 001 and operand B into the row with low bits 010. It then copies a constant row into the row with low bits 000: the zero row for AND, the one row for OR. Next comes a refresh and a recovery wait, then the fast triple-activation step. Finally the result is copied from the 001 row to the destination. Every copy closes the bank with a precharge held for the normal precharge time. A request whose rows lie in different 512-row subarrays, or that carries the reserved opcode, is refused without issuing any command.

Top module: `dseq_top`

## Requirements
- R1: After reset, req_ready is 1, cmd_o is NOP (0), and row_o, bank_o, done_o and err_o are 0. Whenever req_ready is 1, cmd_o is NOP.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until the done cycle, and req_valid and request fields driven while busy have no effect on the command stream.
- R3: Opcode 0 (copy) issues ACT(src_a). req_t1 cycles later it issues PRE, and req_t2 cycles after that ACT(dst). After a further req_t1 cycles it issues PRE. The first command appears in the cycle after acceptance. Command codes: NOP=0, ACT=1, PRE=2, REF=3. row_o carries the row on ACT and is 0 otherwise.
- R4: An interval of 0 is treated as 1, so two commands are never closer than one cycle and no extra command appears in any gap.
- R5: Opcodes 1 (AND) and 2 (OR) first run three copies of the R3 form. The copies are: src_a to subarray offset 1, src_b to offset 2, and the constant row to offset 0. The constant row is at offset 3 (zero) for AND and at offset 4 (one) for OR. The subarray is the upper address bits of src_a.
- R6: After staging, a REF is issued. The next command follows TREFR (5) cycles later.
- R7: The compute step is ACT(offset 1), then PRE in the very next cycle, then ACT(offset 2) req_t2 cycles later, then PRE req_t1 cycles later.
- R8: The result is copied from offset 1 to req_dst with an R3-form copy.
- R9: Every copy and the compute step end with a PRE followed by a TRP (3) cycle wait. After the final wait, done_o pulses for one cycle, and req_ready is 1 in that same cycle.
- R10: If the rows of a request lie in different subarrays (upper ROW_W-9 bits differ), the request is rejected. For a copy the rows compared are src_a and dst; for AND/OR they are src_a, src_b and dst. On rejection err_o pulses for one cycle after acceptance, no command is issued, and req_ready stays 1.
- R11: Opcode 3 is reserved and is rejected like R10.
- R12: bank_o carries the request's bank on every ACT, PRE and REF, and is 0 on NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 copy, 1 AND, 2 OR, 3 reserved |
| req_bank | input | BANK_W | Target bank |
| req_src_a | input | ROW_W | Source row / operand A |
| req_src_b | input | ROW_W | Operand B (logic ops) |
| req_dst | input | ROW_W | Destination row |
| req_t1 | input | CNT_W | ACT-to-PRE interval in cycles |
| req_t2 | input | CNT_W | PRE-to-ACT interval in cycles |
| cmd_o | output | 2 | Command: 0 NOP, 1 ACT, 2 PRE, 3 REF |
| bank_o | output | BANK_W | Bank of the current command |
| row_o | output | ROW_W | Row of an ACT |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |

## Verification
A corrupted step index or wait counter shows up at the command port within one gap of the fault. It appears as a command in a cycle where none was due, a wrong row on an ACT, or a missing command, and the per-cycle comparison against an arithmetically built schedule flags it at once. A stuck busy flag shows as a done pulse missing or arriving at the wrong time, or as req_ready wrong in the done cycle. A wrong subarray test shows as commands where err_o was expected, in the very next cycle.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_PRE = 2'd2,
    CMD_REF = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_AND  = 2'd1,
    OP_OR   = 2'd2,
    OP_RSV  = 2'd3
  } op_e;

  localparam int unsigned IDX_W = 5;

  // last step index of an operation's schedule
  function automatic logic [IDX_W-1:0] last_step(input logic [1:0] op);
    return (op == OP_COPY) ? 5'd3 : 5'd20;
  endfunction
endpackage

// File: rtl/dseq_req_check.sv
module dseq_req_check #(
  parameter int HI_W = 5
) (
  input  logic [1:0]      op,
  input  logic [HI_W-1:0] hi_a,
  input  logic [HI_W-1:0] hi_b,
  input  logic [HI_W-1:0] hi_d,
  output logic            ok
);
  import dseq_pkg::*;

  function automatic logic same_sub(input logic [1:0] o, input logic [HI_W-1:0] a,
                                    input logic [HI_W-1:0] b, input logic [HI_W-1:0] d);
    if (o == OP_RSV) return 1'b0;
    if (a != d) return 1'b0;
    return (o == OP_COPY) || (a == b);
  endfunction

  assign ok = same_sub(op, hi_a, hi_b, hi_d);
endmodule

// File: rtl/dseq_prog.sv
module dseq_prog #(
  parameter int ROW_W  = 14,
  parameter int SUB_W  = 9,
  parameter int CNT_W  = 6,
  parameter int TRP    = 3,
  parameter int TREFR  = 5,
  parameter int CZ_OFS = 3,
  parameter int CO_OFS = 4
) (
  input  logic [1:0]                 op,
  input  logic [dseq_pkg::IDX_W-1:0] idx,
  input  logic [ROW_W-1:0]           ra,
  input  logic [ROW_W-1:0]           rb,
  input  logic [ROW_W-1:0]           rd,
  input  logic [CNT_W-1:0]           t1,
  input  logic [CNT_W-1:0]           t2,
  output dseq_pkg::cmd_e             cmd,
  output logic [ROW_W-1:0]           row,
  output logic [CNT_W-1:0]           gap,
  output logic                       last,
  output logic                       fast_act
);
  import dseq_pkg::*;

  localparam int HI_W = ROW_W - SUB_W;
  localparam logic [CNT_W-1:0] G_TRP = CNT_W'(TRP);
  localparam logic [CNT_W-1:0] G_REF = CNT_W'(TREFR);

  function automatic logic [CNT_W-1:0] clamp1(input logic [CNT_W-1:0] t);
    return (t == '0) ? CNT_W'(1) : t;
  endfunction

  function automatic logic [ROW_W-1:0] sub_row(input logic [HI_W-1:0] h, input int ofs);
    return {h, SUB_W'(ofs)};
  endfunction

  logic [HI_W-1:0]  hi;
  logic [CNT_W-1:0] g1, g2;
  logic [ROW_W-1:0] r1, r2, r3, rc;
  logic [ROW_W-1:0] src, dst;
  logic [1:0]       sub;
  logic             in_copy;

  assign hi = ra[ROW_W-1:SUB_W];
  assign g1 = clamp1(t1);
  assign g2 = clamp1(t2);
  assign r1 = sub_row(hi, 1);
  assign r2 = sub_row(hi, 2);
  assign r3 = sub_row(hi, 0);
  assign rc = (op == OP_OR) ? sub_row(hi, CO_OFS) : sub_row(hi, CZ_OFS);

  always_comb begin
    in_copy = 1'b1;
    sub     = idx[1:0];
    src     = ra;
    dst     = rd;
    if (op != OP_COPY) begin
      if (idx < 5'd4) begin
        dst = r1;
      end else if (idx < 5'd8) begin
        src = rb; dst = r2;
      end else if (idx < 5'd12) begin
        src = rc; dst = r3;
      end else if (idx < 5'd17) begin
        in_copy = 1'b0;
      end else begin
        sub = 2'(idx - 5'd17);
        src = r1;
      end
    end
    cmd = CMD_PRE;
    row = '0;
    gap = g1;
    if (in_copy) begin
      case (sub)
        2'd0:    begin cmd = CMD_ACT; row = src; gap = g1; end
        2'd1:    begin cmd = CMD_PRE; gap = g2; end
        2'd2:    begin cmd = CMD_ACT; row = dst; gap = g1; end
        default: begin cmd = CMD_PRE; gap = G_TRP; end
      endcase
    end else begin
      case (idx)
        5'd12:   begin cmd = CMD_REF; gap = G_REF; end
        5'd13:   begin cmd = CMD_ACT; row = r1; gap = CNT_W'(1); end
        5'd14:   begin cmd = CMD_PRE; gap = g2; end
        5'd15:   begin cmd = CMD_ACT; row = r2; gap = g1; end
        default: begin cmd = CMD_PRE; gap = G_TRP; end
      endcase
    end
  end

  assign last     = (idx == last_step(op));
  assign fast_act = !in_copy && (idx == 5'd13);
endmodule

// File: rtl/dseq_gap_timer.sv
module dseq_gap_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] span,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= span - CNT_W'(1);
    else if (cnt != '0)      cnt <= cnt - CNT_W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dseq_top.sv
module dseq_top #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int SUB_W  = 9,
  parameter int CNT_W  = 6,
  parameter int TRP    = 3,
  parameter int TREFR  = 5,
  parameter int CZ_OFS = 3,
  parameter int CO_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_src_a,
  input  logic [ROW_W-1:0]  req_src_b,
  input  logic [ROW_W-1:0]  req_dst,
  input  logic [CNT_W-1:0]  req_t1,
  input  logic [CNT_W-1:0]  req_t2,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              done_o,
  output logic              err_o
);
  import dseq_pkg::*;

  localparam int HI_W = ROW_W - SUB_W;

  logic              busy, tail;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        op_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  ra_q, rb_q, rd_q;
  logic [CNT_W-1:0]  t1_q, t2_q;

  logic             req_ok, tmr_done;
  cmd_e             p_cmd;
  logic [ROW_W-1:0] p_row;
  logic [CNT_W-1:0] p_gap;
  logic             p_last, p_fast;

  // named internal events
  logic ev_accept, ev_reject, ev_issue, ev_finish, ev_fast_pre;
  assign ev_accept   = !busy && req_valid && req_ok;
  assign ev_reject   = !busy && req_valid && !req_ok;
  assign ev_issue    = busy && tmr_done && !tail;
  assign ev_finish   = busy && tmr_done && tail;
  assign ev_fast_pre = ev_issue && p_fast;

  dseq_req_check #(.HI_W(HI_W)) u_chk (
    .op   (req_op),
    .hi_a (req_src_a[ROW_W-1:SUB_W]),
    .hi_b (req_src_b[ROW_W-1:SUB_W]),
    .hi_d (req_dst[ROW_W-1:SUB_W]),
    .ok   (req_ok)
  );

  dseq_prog #(
    .ROW_W(ROW_W), .SUB_W(SUB_W), .CNT_W(CNT_W), .TRP(TRP),
    .TREFR(TREFR), .CZ_OFS(CZ_OFS), .CO_OFS(CO_OFS)
  ) u_prog (
    .op(op_q), .idx(idx), .ra(ra_q), .rb(rb_q), .rd(rd_q),
    .t1(t1_q), .t2(t2_q),
    .cmd(p_cmd), .row(p_row), .gap(p_gap), .last(p_last), .fast_act(p_fast)
  );

  dseq_gap_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(ev_issue), .span(p_gap), .expired(tmr_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; tail <= 1'b0; idx <= '0; op_q <= '0; bank_q <= '0;
      ra_q <= '0; rb_q <= '0; rd_q <= '0; t1_q <= '0; t2_q <= '0;
      cmd_o <= CMD_NOP; bank_o <= '0; row_o <= '0; done_o <= 1'b0; err_o <= 1'b0;
    end else begin
      cmd_o  <= CMD_NOP;
      bank_o <= '0;
      row_o  <= '0;
      done_o <= 1'b0;
      err_o  <= ev_reject;
      if (ev_accept) begin
        busy <= 1'b1; tail <= 1'b0; idx <= '0;
        op_q <= req_op; bank_q <= req_bank;
        ra_q <= req_src_a; rb_q <= req_src_b; rd_q <= req_dst;
        t1_q <= req_t1; t2_q <= req_t2;
      end
      if (ev_issue) begin
        cmd_o  <= p_cmd;
        row_o  <= p_row;
        bank_o <= bank_q;
        idx    <= idx + IDX_W'(1);
        tail   <= p_last;
      end
      if (ev_finish) begin
        busy   <= 1'b0;
        tail   <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  assign req_ready = !busy;
endmodule

// File: rtl/dseq_sva.sv
module dseq_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] cmd_o,
  input logic       done_o,
  input logic       err_o,
  input logic       ev_fast_pre
);
  import dseq_pkg::*;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cmd_o == CMD_NOP);

  p_take_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready || err_o);

  p_fast_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fast_pre |-> ##2 cmd_o == CMD_PRE);

  p_act_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fast_pre |=> cmd_o == CMD_ACT);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> req_ready);

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> req_ready && cmd_o == CMD_NOP && !done_o);
endmodule

bind dseq_top dseq_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_o(cmd_o), .done_o(done_o), .err_o(err_o), .ev_fast_pre(ev_fast_pre)
);

// File: tb/sim_dseq_top.sv
`timescale 1ns/1ps
module sim_dseq_top;
  localparam int BW = 3, RW = 14, CW = 6;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [BW-1:0] req_bank = '0;
  logic [RW-1:0] req_src_a = '0, req_src_b = '0, req_dst = '0;
  logic [CW-1:0] req_t1 = '0, req_t2 = '0;
  logic [1:0]    cmd_o;
  logic [BW-1:0] bank_o;
  logic [RW-1:0] row_o;
  logic          done_o, err_o;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dseq_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .req_src_a(req_src_a), .req_src_b(req_src_b),
    .req_dst(req_dst), .req_t1(req_t1), .req_t2(req_t2),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .done_o(done_o), .err_o(err_o)
  );

  // expected schedule
  int            e_n;
  logic [1:0]    e_cmd [64];
  logic [RW-1:0] e_row [64];
  int            e_gap [64];
  string         e_tag [64];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] c, input logic [RW-1:0] r, input int g, input string t);
    e_cmd[e_n] = c; e_row[e_n] = r; e_gap[e_n] = g; e_tag[e_n] = t; e_n++;
  endtask

  task automatic push_copy(input logic [RW-1:0] s, input logic [RW-1:0] d,
                           input int g1, input int g2, input string t);
    push(2'd1, s, g1, t);
    push(2'd2, '0, g2, t);
    push(2'd1, d, g1, t);
    push(2'd2, '0, 3, "R9");
  endtask

  function automatic logic [RW-1:0] at(input logic [RW-1:0] a, input int ofs);
    return RW'((int'(a) / 512) * 512 + ofs);
  endfunction

  task automatic build(input logic [1:0] op, input logic [RW-1:0] a, input logic [RW-1:0] b,
                       input logic [RW-1:0] d, input int t1, input int t2);
    int g1, g2;
    g1 = (t1 == 0) ? 1 : t1;
    g2 = (t2 == 0) ? 1 : t2;
    e_n = 0;
    if (op == 2'd0) begin
      push_copy(a, d, g1, g2, "R3");
    end else begin
      push_copy(a, at(a, 1), g1, g2, "R5");
      push_copy(b, at(a, 2), g1, g2, "R5");
      push_copy(at(a, (op == 2'd1) ? 3 : 4), at(a, 0), g1, g2, "R5");
      push(2'd3, '0, 5, "R6");
      push(2'd1, at(a, 1), 1, "R7");
      push(2'd2, '0, g2, "R7");
      push(2'd1, at(a, 2), g1, "R7");
      push(2'd2, '0, 3, "R9");
      push_copy(at(a, 1), d, g1, g2, "R8");
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [BW-1:0] bk, input logic [RW-1:0] a,
                       input logic [RW-1:0] b, input logic [RW-1:0] d, input int t1, input int t2);
    req_valid = 1'b1; req_op = op; req_bank = bk;
    req_src_a = a; req_src_b = b; req_dst = d;
    req_t1 = CW'(t1); req_t2 = CW'(t2);
  endtask

  task automatic run_ok(input logic [1:0] op, input logic [BW-1:0] bk, input logic [RW-1:0] a,
                        input logic [RW-1:0] b, input logic [RW-1:0] d,
                        input int t1, input int t2, input bit noisy);
    int total, k, nxt;
    build(op, a, b, d, t1, t2);
    total = 1;
    for (int i = 0; i < e_n; i++) total += e_gap[i];
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 ready before request", req_ready, 1);
    drive(op, bk, a, b, d, t1, t2);
    @(negedge clk);
    k = 0; nxt = 1;
    for (int n = 1; n <= total; n++) begin
      if (noisy && n < total) drive(2'd3, ~bk, '1, '0, '1, 0, 0);  // R2: ignored while busy
      else req_valid = 1'b0;
      @(negedge clk);
      if (k < e_n && n == nxt) begin
        chk(cmd_o === e_cmd[k], {e_tag[k], " command"}, cmd_o, e_cmd[k]);
        chk(row_o === e_row[k], {e_tag[k], " row"}, row_o, e_row[k]);
        chk(bank_o === bk, "R12 bank", bank_o, bk);
        nxt = nxt + e_gap[k];
        k++;
      end else if (cmd_o !== 2'd0 || bank_o !== '0) begin
        chk(1'b0, "R4 unexpected command in gap", cmd_o, 0);
      end
      if (n == total) begin
        chk(done_o === 1'b1, "R9 done pulse", done_o, 1);
        chk(req_ready === 1'b1, "R9 ready at done", req_ready, 1);
      end else if (done_o !== 1'b0 || req_ready !== 1'b0) begin
        chk(1'b0, "R2 busy/done early", {done_o, req_ready}, 0);
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(done_o === 1'b0 && cmd_o === 2'd0, "R9 done one cycle", done_o, 0);
  endtask

  task automatic run_err(input logic [1:0] op, input logic [RW-1:0] a, input logic [RW-1:0] b,
                         input logic [RW-1:0] d, input string tag);
    @(negedge clk);
    drive(op, 3'd5, a, b, d, 2, 2);
    @(negedge clk);
    req_valid = 1'b0;
    chk(err_o === 1'b1, {tag, " err pulse"}, err_o, 1);
    chk(req_ready === 1'b1 && cmd_o === 2'd0, {tag, " no command, ready"}, {req_ready, cmd_o}, 4);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(err_o === 1'b0 && cmd_o === 2'd0 && done_o === 1'b0, {tag, " quiet after reject"},
          {err_o, cmd_o, done_o}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 reset ready", req_ready, 1);
    chk(cmd_o === 2'd0 && row_o === '0 && bank_o === '0, "R1 reset bus", cmd_o, 0);
    chk(done_o === 1'b0 && err_o === 1'b0, "R1 reset flags", {done_o, err_o}, 0);

    for (int op = 0; op < 3; op++)
      for (int t1 = 0; t1 < 4; t1++)
        for (int t2 = 0; t2 < 4; t2++) begin
          int sb;
          logic [RW-1:0] a, b, d;
          sb = (op * 16 + t1 * 4 + t2) % 32;
          a = RW'(sb * 512 + 100 + t1);
          b = RW'(sb * 512 + 300 + t2);
          d = RW'(sb * 512 + 511 - t1 - t2);
          run_ok(2'(op), BW'(t1 + t2 + op), a, b, d, t1, t2, t2 == 3);
        end

    // R10: subarray mismatches; R11: reserved opcode
    run_err(2'd0, 14'd700, 14'd0, 14'd100, "R10 copy");
    run_err(2'd1, 14'd1030, 14'd2000, 14'd1100, "R10 and-b");
    run_err(2'd2, 14'd1030, 14'd1040, 14'd5000, "R10 or-d");
    run_err(2'd3, 14'd10, 14'd20, 14'd30, "R11 reserved");
    // a valid request still works after rejection
    run_ok(2'd0, 3'd7, 14'd16383, 14'd0, 14'd15872, 5, 2, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule